// File: doc/BRIEF.md
# Resistive Touch Panel Switch Decoder and Pen Interrupt Control

This block converts a touch-panel conversion setting into enables for the four panel plate drivers (X+, X-, Y+, Y-). It also produces the analog input select code and a flag that chooses between the external reference and the driven plates. A conversion sequencer supplies one-cycle strobes that mark the phases of a conversion: start detected, acquisition begins, hold begins, and conversion finished. The block latches the channel and reference-mode bits when acquisition begins and the power-management bits when hold begins. The plate drivers follow the phase. In single-ended mode they are released at hold. In differential (ratiometric) mode they stay on through the conversion.

Between conversions the block runs the pen-touch interrupt. The interrupt is armed out of reset. A detected start disarms it. When a conversion finishes it is re-armed only if the power bits latched for that conversion allow it. While the block is idle and the interrupt is enabled, Y- is turned on so that a touch pulls the sense node, which arrives here as a synchronised `touch` level. The interrupt pin is open-drain, so the block only ever asserts an enable that pulls it low.

Power setting 11 keeps the plate drivers on after a conversion. They stay on until the live channel, reference-mode or power inputs differ from the latched ones.

Top module: `touch_panel_ctrl`

## Requirements
- R1: While acquiring, channel 001 turns on Y+ and Y-, and channel 101 turns on X+ and X-. The input select `ain_sel` is 0 for X+ (001), 1 for Y+ (101), 2 for auxiliary A (010, single-ended only) and 3 for auxiliary B (110, single-ended). Auxiliary channels drive no plate.
- R2: Channel 110 with reference-mode 0 raises `ident`, drives no plate and selects `ain_sel` 3. Every other combination outside R1 raises `cfg_bad`, drives no plate and selects `ain_sel` 0.
- R3: `ref_ext` is 0 only for differential mode (`ref_single` = 0) on channel 001 or 101. In every other case it is 1.
- R4: During hold/conversion the plate drivers are off in single-ended mode and stay as in R1 in differential mode.
- R5: While idle, Y- alone is on when latched power bit 0 is 0 (settings 00 and 10). It is off for settings 01 and 11 unless R6 holds the drivers.
- R6: After a conversion with power setting 11, the R1 drivers remain on. They switch off in the cycle after `chan_sel`, `ref_single` or `pwr_mode` differ from the latched values.
- R7: After reset the interrupt is armed, the latched power setting is 00, the latched channel is 000 with `ref_single` 1 (so `cfg_bad` = 1), and only Y- is on.
- R8: A `start_det` strobe disarms the interrupt from the next cycle until the conversion finishes, whatever `touch` does.
- R9: At `conv_done` the interrupt is re-armed if latched power bit 0 is 0, and stays disarmed if it is 1.
- R10: `irq_pull` is 1 only while the interrupt is armed and `touch` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_sel | input | 3 | Channel select bits |
| ref_single | input | 1 | 1 = single-ended reference, 0 = differential |
| pwr_mode | input | 2 | Power-management setting |
| start_det | input | 1 | Strobe: start bit detected |
| acq_phase | input | 1 | Strobe: acquisition begins, latch channel/reference |
| hold_phase | input | 1 | Strobe: hold begins, latch power bits |
| conv_done | input | 1 | Strobe: conversion finished |
| touch | input | 1 | Synchronised touch-detect level |
| xp_en | output | 1 | X+ driver enable |
| xn_en | output | 1 | X- driver enable |
| yp_en | output | 1 | Y+ driver enable |
| yn_en | output | 1 | Y- driver enable |
| ain_sel | output | 2 | Analog input select code |
| ref_ext | output | 1 | 1 = external reference, 0 = plate reference |
| ident | output | 1 | Identity-code request |
| cfg_bad | output | 1 | Latched setting is invalid |
| irq_pull | output | 1 | Open-drain pull-low enable for the pen interrupt |

## Verification
The hardest state to reach is setting 11 holding the drivers after a conversion and then releasing them. It needs a full start, acquire, hold and done sequence with constant inputs, followed by a change to a single input while idle. The vector loop runs complete sequences back to back, and each sequence moves the inputs first, so a held configuration is always dropped by the next vector. A directed test changes only `pwr_mode` after a hold to check the release on that input alone. Another directed test strobes start and done with no acquisition in between, to check that the interrupt is disarmed and re-armed outside a normal conversion.

// File: rtl/touch_panel_ctrl.sv
module touch_panel_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] chan_sel,
  input  logic       ref_single,
  input  logic [1:0] pwr_mode,
  input  logic       start_det,
  input  logic       acq_phase,
  input  logic       hold_phase,
  input  logic       conv_done,
  input  logic       touch,
  output logic       xp_en,
  output logic       xn_en,
  output logic       yp_en,
  output logic       yn_en,
  output logic [1:0] ain_sel,
  output logic       ref_ext,
  output logic       ident,
  output logic       cfg_bad,
  output logic       irq_pull
);

  typedef enum logic [1:0] {ST_IDLE, ST_PRE, ST_ACQ, ST_CONV} stage_t;

  stage_t     stage;
  logic [2:0] chan_q;
  logic       ref_q;
  logic [1:0] pwr_q;
  logic       keep;
  logic       armed;
  logic       cfg_diff;

  assign cfg_diff = (chan_sel != chan_q) || (ref_single != ref_q) || (pwr_mode != pwr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage  <= ST_IDLE;
      chan_q <= 3'b000;
      ref_q  <= 1'b1;
      pwr_q  <= 2'b00;
      keep   <= 1'b0;
      armed  <= 1'b1;
    end else begin
      if (start_det) begin
        stage <= ST_PRE;
        armed <= 1'b0;
      end else if (conv_done) begin
        stage <= ST_IDLE;
        armed <= ~pwr_q[0];
      end else if (hold_phase) begin
        stage <= ST_CONV;
        pwr_q <= pwr_mode;
      end else if (acq_phase) begin
        stage  <= ST_ACQ;
        chan_q <= chan_sel;
        ref_q  <= ref_single;
      end

      if (acq_phase && !start_det)
        keep <= 1'b0;
      else if (conv_done && !start_det)
        keep <= (pwr_q == 2'b11);
      else if (stage == ST_IDLE && cfg_diff)
        keep <= 1'b0;
    end
  end

  logic sel_x, sel_y, drv, sense;

  always_comb begin
    ain_sel = 2'd0;
    ident   = 1'b0;
    cfg_bad = 1'b0;
    unique case ({chan_q, ref_q})
      4'b0011, 4'b0010: ain_sel = 2'd0;
      4'b1011, 4'b1010: ain_sel = 2'd1;
      4'b0101:          ain_sel = 2'd2;
      4'b1101:          ain_sel = 2'd3;
      4'b1100: begin
        ain_sel = 2'd3;
        ident   = 1'b1;
      end
      default:          cfg_bad = 1'b1;
    endcase
  end

  assign sel_y   = (chan_q == 3'b001);
  assign sel_x   = (chan_q == 3'b101);
  assign ref_ext = ref_q | ~(sel_x | sel_y);
  assign drv     = (stage == ST_ACQ) || (stage == ST_CONV && !ref_ext) || keep;
  assign sense   = (stage == ST_IDLE) && !keep && !pwr_q[0];

  assign xp_en    = drv & sel_x;
  assign xn_en    = drv & sel_x;
  assign yp_en    = drv & sel_y;
  assign yn_en    = (drv & sel_y) | sense;
  assign irq_pull = armed & touch;

  a_r8_start_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !irq_pull);

  a_r10_pull_needs_touch: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pull |-> touch);

  a_r4_single_conv_off: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == ST_CONV && ref_q) |-> !(xp_en || xn_en || yp_en || yn_en));

  a_r9_no_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !start_det && pwr_q[0]) |=> !irq_pull);

  a_r2_bad_no_plate: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_bad && stage != ST_IDLE) |-> !(xp_en || xn_en || yp_en || yn_en));

  a_r1_x_y_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(xp_en && yp_en));

endmodule

// File: tb/touch_panel_ctrl_test.sv
`timescale 1ns/1ps
module touch_panel_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] chan_sel = 3'b000;
  logic       ref_single = 1'b1;
  logic [1:0] pwr_mode = 2'b00;
  logic       start_det = 1'b0, acq_phase = 1'b0, hold_phase = 1'b0, conv_done = 1'b0;
  logic       touch = 1'b0;
  logic       xp_en, xn_en, yp_en, yn_en, ref_ext, ident, cfg_bad, irq_pull;
  logic [1:0] ain_sel;

  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;

  always #2.5 clk = ~clk;

  touch_panel_ctrl uut (
    .clk(clk), .rst_n(rst_n), .chan_sel(chan_sel), .ref_single(ref_single),
    .pwr_mode(pwr_mode), .start_det(start_det), .acq_phase(acq_phase),
    .hold_phase(hold_phase), .conv_done(conv_done), .touch(touch),
    .xp_en(xp_en), .xn_en(xn_en), .yp_en(yp_en), .yn_en(yn_en),
    .ain_sel(ain_sel), .ref_ext(ref_ext), .ident(ident), .cfg_bad(cfg_bad),
    .irq_pull(irq_pull)
  );

  // fields: chan[22:20] ref[19] pwr[18:17] acq{xp,xn,yp,yn}[16:13]
  // conv[12:9] idle[8:5] ain[4:3] ref_ext[2] ident[1] bad[0]
  localparam int NV = 10;
  localparam logic [22:0] VEC [NV] = '{
    {3'b001, 1'b1, 2'b00, 4'b0011, 4'b0000, 4'b0001, 2'd0, 1'b1, 1'b0, 1'b0},
    {3'b001, 1'b0, 2'b10, 4'b0011, 4'b0011, 4'b0001, 2'd0, 1'b0, 1'b0, 1'b0},
    {3'b101, 1'b1, 2'b01, 4'b1100, 4'b0000, 4'b0000, 2'd1, 1'b1, 1'b0, 1'b0},
    {3'b101, 1'b0, 2'b11, 4'b1100, 4'b1100, 4'b1100, 2'd1, 1'b0, 1'b0, 1'b0},
    {3'b010, 1'b1, 2'b00, 4'b0000, 4'b0000, 4'b0001, 2'd2, 1'b1, 1'b0, 1'b0},
    {3'b110, 1'b1, 2'b10, 4'b0000, 4'b0000, 4'b0001, 2'd3, 1'b1, 1'b0, 1'b0},
    {3'b110, 1'b0, 2'b00, 4'b0000, 4'b0000, 4'b0001, 2'd3, 1'b1, 1'b1, 1'b0},
    {3'b010, 1'b0, 2'b00, 4'b0000, 4'b0000, 4'b0001, 2'd0, 1'b1, 1'b0, 1'b1},
    {3'b111, 1'b1, 2'b01, 4'b0000, 4'b0000, 4'b0000, 2'd0, 1'b1, 1'b0, 1'b1},
    {3'b001, 1'b0, 2'b11, 4'b0011, 4'b0011, 4'b0011, 2'd0, 1'b0, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: start_det = 1'b1;
      1: acq_phase = 1'b1;
      2: hold_phase = 1'b1;
      default: conv_done = 1'b1;
    endcase
    @(negedge clk);
    {start_det, acq_phase, hold_phase, conv_done} = 4'b0;
    #1;
  endtask

  function automatic logic [3:0] plates();
    return {xp_en, xn_en, yp_en, yn_en};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    touch = 1'b1;
    #1;
    check("R7 plates", 32'(plates()), 32'b0001);
    check("R7 irq armed", 32'(irq_pull), 32'd1);
    check("R7 bad setting", 32'(cfg_bad), 32'd1);
    check("R7 ref_ext", 32'(ref_ext), 32'd1);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [22:0] v;
      v = VEC[i];
      @(negedge clk);
      chan_sel = v[22:20]; ref_single = v[19]; pwr_mode = v[18:17]; touch = 1'b1;
      repeat (2) @(negedge clk);
      pulse(0);
      check("R8 disarm after start", 32'(irq_pull), 32'd0);
      pulse(1);
      check("R1 acq plates", 32'(plates()), 32'(v[16:13]));
      check("R1 ain_sel", 32'(ain_sel), 32'(v[4:3]));
      check("R3 ref_ext", 32'(ref_ext), 32'(v[2]));
      check("R2 ident", 32'(ident), 32'(v[1]));
      check("R2 cfg_bad", 32'(cfg_bad), 32'(v[0]));
      check("R8 disarmed in acq", 32'(irq_pull), 32'd0);
      pulse(2);
      check("R4 conv plates", 32'(plates()), 32'(v[12:9]));
      pulse(3);
      check("R5 R6 idle plates", 32'(plates()), 32'(v[8:5]));
      check("R9 rearm", 32'(irq_pull), 32'(!v[17]));
    end

    // last vector held plates with setting 11; change only pwr_mode
    @(negedge clk);
    pwr_mode = 2'b10;
    @(negedge clk); #1;
    check("R6 release on power change", 32'(plates()), 32'b0000);
    check("R9 stays disarmed", 32'(irq_pull), 32'd0);

    // arm again via a 00 conversion, then touch low gives no pull
    chan_sel = 3'b101; ref_single = 1'b1; pwr_mode = 2'b00;
    pulse(0); pulse(1); pulse(2); pulse(3);
    check("R9 rearm with 00", 32'(irq_pull), 32'd1);
    @(negedge clk); touch = 1'b0; #1;
    check("R10 no pull without touch", 32'(irq_pull), 32'd0);
    @(negedge clk); touch = 1'b1; #1;
    check("R10 pull with touch", 32'(irq_pull), 32'd1);

    // start then done with no acquisition in between
    pulse(0);
    check("R8 start only", 32'(irq_pull), 32'd0);
    check("R5 Y- off during sequence", 32'(yn_en), 32'd0);
    @(negedge clk); touch = 1'b0; @(negedge clk); touch = 1'b1; #1;
    check("R8 stays disarmed", 32'(irq_pull), 32'd0);
    pulse(3);
    check("R9 rearm after bare done", 32'(irq_pull), 32'd1);
    check("R5 Y- sense back", 32'(plates()), 32'b0001);

    done_flag = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done_flag && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done_flag) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule